// File: doc/BRIEF.md
# Write-only serial register port

This block is the slave end of a three-wire serial control link. Its job is to load an internal bank of configuration registers. A host lowers an active-low select line and shifts bits in on the rising edges of a serial clock. The first byte it sends is a header. The header holds a seven-bit device identifier and a direction bit. The second byte is a register pointer. Every byte after that is data, and each one lands in the register the pointer names.

Bit seven of the pointer byte chooses one of two modes. In the first mode the pointer walks forward after each data byte, so a burst fills consecutive registers. In the second mode the pointer holds still, so every byte of the burst overwrites the same register. The port never drives anything back to the host. A read request is simply dropped, and so is a header carrying a foreign identifier.

The serial lines are resynchronised into the system clock domain and edge-detected, so the whole port runs on one clock. The chip-side logic reads any register through a combinational read port. Each accepted write also appears as a single-cycle strobe with its address and data.

Top module: `ctlp_top`

## Requirements
- R1: Serial data is sampled on each rising edge of the serial clock while select is low, most significant bit first within every byte.
- R2: The first seven bits of a transfer must equal 1001010; any other identifier makes the port ignore the whole transfer.
- R3: The eighth bit is the direction flag. A value of 1 (header byte 0x95) marks a read, and the whole transfer is ignored. Only a value of 0 (header byte 0x94) is acted on.
- R4: The second byte is the pointer. Bit 7 enables auto-advance, and bits 6:0 give the register address.
- R5: Each complete byte after the pointer produces exactly one single-cycle write strobe, carrying the current pointer as address and the byte as data. The addressed register holds that byte afterwards.
- R6: With auto-advance set, the pointer increases by one after each data byte and wraps from 127 to 0.
- R7: With auto-advance clear, the pointer stays fixed, so later data bytes overwrite the same register.
- R8: Raising select at any point ends the transfer and discards a partly received byte. The next falling edge of select restarts counting at the first header bit.
- R9: A transfer begins only on a high-to-low transition of select seen after reset is released. If select is already low when reset ends, the bits clocked in are ignored until select rises and falls again.
- R10: After reset all 128 registers read zero and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Active-low select from the host |
| sclk_i | input | 1 | Serial bit clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| rd_addr_i | input | 7 | Chip-side register read address |
| rd_data_o | output | 8 | Contents of the register at rd_addr_i |
| wr_stb_o | output | 1 | One-cycle pulse for each accepted data byte |
| wr_addr_o | output | 7 | Register address of the current write |
| wr_data_o | output | 8 | Data byte of the current write |

## Verification
The bench targets several corner cases, and each has a visible symptom when the design is wrong.

- Pointer wrap: a burst starting at register 127 must continue at register 0. A design that failed to wrap would write past the top of the bank or stop advancing.
- Fixed-pointer mode: repeated bytes must all go to one register. A design that advanced anyway would scatter them across neighbouring registers.
- Rejected headers: read requests and foreign identifiers must change nothing. A design that accepted them would alter registers.
- Select rising mid-byte: the partial byte must be dropped. A design that kept the bit count would write a spurious byte, or misalign the next transfer.
- Select low when reset ends: the port must wait for a real falling edge. A design that treated this as a start would load registers from a frame it never saw begin.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PTR,
    ST_DATA,
    ST_SKIP
  } fr_state_t;

  // Header is accepted only for the matching identifier with the direction bit low.
  function automatic logic hdr_ok(input logic [7:0] hdr, input logic [6:0] id);
    return hdr == {id, 1'b0};
  endfunction

  // Pointer after a data byte: advance with wrap, or hold.
  function automatic logic [6:0] ptr_next(input logic [6:0] ptr, input logic inc);
    return inc ? ptr + 7'd1 : ptr;
  endfunction

endpackage

// File: rtl/ctlp_sync.sv
module ctlp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic cs_fall_o,
  output logic cs_high_o,
  output logic sclk_rise_o,
  output logic sdi_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] cs_sh, ck_sh, di_sh;
  logic              cs_prev, ck_prev;

  // Select chain resets to 0 so a select held low through reset is not seen as a fall (R9).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sh   <= '0;
      ck_sh   <= '0;
      di_sh   <= '0;
      cs_prev <= 1'b0;
      ck_prev <= 1'b0;
    end else begin
      cs_sh   <= {cs_sh[STAGES-2:0], csn_i};
      ck_sh   <= {ck_sh[STAGES-2:0], sclk_i};
      di_sh   <= {di_sh[STAGES-2:0], sdi_i};
      cs_prev <= cs_sh[LAST];
      ck_prev <= ck_sh[LAST];
    end
  end

  assign cs_fall_o   = cs_prev & ~cs_sh[LAST];
  assign cs_high_o   = cs_sh[LAST];
  assign sclk_rise_o = ck_sh[LAST] & ~ck_prev;
  assign sdi_o       = di_sh[LAST];

  // R1
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise_o |=> !sclk_rise_o);

  // R8
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_o |=> !cs_fall_o);

endmodule

// File: rtl/ctlp_frame.sv
module ctlp_frame
  import ctlp_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'b1001010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_fall_i,
  input  logic       cs_high_i,
  input  logic       sclk_rise_i,
  input  logic       sdi_i,
  output logic       wr_stb_o,
  output logic [6:0] wr_addr_o,
  output logic [7:0] wr_data_o
);
  fr_state_t  state_q;
  logic [2:0] bitcnt_q;
  logic [6:0] shreg_q;
  logic [6:0] ptr_q;
  logic       inc_q;
  logic       hdr_seen_q;

  logic       shifting;
  logic       byte_done;
  logic [7:0] full_byte;

  assign shifting  = sclk_rise_i && !cs_high_i &&
                     (state_q == ST_HDR || state_q == ST_PTR || state_q == ST_DATA);
  assign full_byte = {shreg_q, sdi_i};
  assign byte_done = shifting && (bitcnt_q == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      ptr_q      <= '0;
      inc_q      <= 1'b0;
      hdr_seen_q <= 1'b0;
      wr_stb_o   <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (cs_high_i) begin
        state_q    <= ST_IDLE;
        hdr_seen_q <= 1'b0;
      end else if (cs_fall_i) begin
        state_q    <= ST_HDR;
        bitcnt_q   <= '0;
        shreg_q    <= '0;
        hdr_seen_q <= 1'b0;
      end else if (shifting) begin
        shreg_q  <= full_byte[6:0];
        bitcnt_q <= bitcnt_q + 3'd1;
        if (byte_done) begin
          unique case (state_q)
            ST_HDR: begin
              if (hdr_ok(full_byte, DEV_ID)) begin
                state_q    <= ST_PTR;
                hdr_seen_q <= 1'b1;
              end else begin
                state_q <= ST_SKIP;
              end
            end
            ST_PTR: begin
              ptr_q   <= full_byte[6:0];
              inc_q   <= full_byte[7];
              state_q <= ST_DATA;
            end
            ST_DATA: begin
              wr_stb_o  <= 1'b1;
              wr_addr_o <= ptr_q;
              wr_data_o <= full_byte;
              ptr_q     <= ptr_next(ptr_q, inc_q);
            end
            default: state_q <= ST_SKIP;
          endcase
        end
      end
    end
  end

  // R2
  hdr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> hdr_seen_q);

  // R5
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  // R6
  ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_o && inc_q) |-> (ptr_q == wr_addr_o + 7'd1));

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_o && !inc_q) |-> (ptr_q == wr_addr_o));

  // R8
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high_i |=> !wr_stb_o);

endmodule

// File: rtl/ctlp_regbank.sv
module ctlp_regbank #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[g] <= '0;
      else if (wr_en_i && (wr_addr_i == AW'(g)))
        mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R5
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mem_q[$past(wr_addr_i)] == $past(wr_data_i)));

endmodule

// File: rtl/ctlp_top.sv
module ctlp_top #(
  parameter logic [6:0] DEV_ID = 7'b1001010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csn_i,
  input  logic       sclk_i,
  input  logic       sdi_i,
  input  logic [6:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       wr_stb_o,
  output logic [6:0] wr_addr_o,
  output logic [7:0] wr_data_o
);
  logic cs_fall, cs_high, sclk_rise, sdi_s;

  ctlp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .csn_i       (csn_i),
    .sclk_i      (sclk_i),
    .sdi_i       (sdi_i),
    .cs_fall_o   (cs_fall),
    .cs_high_o   (cs_high),
    .sclk_rise_o (sclk_rise),
    .sdi_o       (sdi_s)
  );

  ctlp_frame #(.DEV_ID(DEV_ID)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_fall_i   (cs_fall),
    .cs_high_i   (cs_high),
    .sclk_rise_i (sclk_rise),
    .sdi_i       (sdi_s),
    .wr_stb_o    (wr_stb_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o)
  );

  ctlp_regbank #(.AW(7), .DW(8)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_stb_o),
    .wr_addr_i (wr_addr_o),
    .wr_data_i (wr_data_o),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: tb/sim_ctlp_top.sv
`timescale 1ns/1ps
module sim_ctlp_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csn_i = 1'b1;
  logic       sclk_i = 1'b0;
  logic       sdi_i = 1'b0;
  logic [6:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       wr_stb_o;
  logic [6:0] wr_addr_o;
  logic [7:0] wr_data_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]  model_bank [128];
  logic [7:0]  tx_q [$];
  logic [14:0] exp_q [$];

  always #2.5 clk = ~clk;

  ctlp_top u0 (
    .clk(clk), .rst_n(rst_n), .csn_i(csn_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Every clock: any strobe must match the next queued expected write.
  always @(negedge clk) begin
    if (rst_n && wr_stb_o) begin
      if (exp_q.size() == 0) begin
        check("R5 unexpected strobe", {1'b1, wr_addr_o, wr_data_o}, 0);
      end else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        check("R5 strobe addr/data", {wr_addr_o, wr_data_o}, e);
      end
    end
  end

  // Behavioural model of a transfer held in tx_q.
  task automatic model_xfer();
    int p;
    bit inc;
    if (tx_q.size() < 2 || tx_q[0] != 8'h94) return;
    p   = int'(tx_q[1][6:0]);
    inc = tx_q[1][7];
    for (int k = 2; k < tx_q.size(); k++) begin
      exp_q.push_back({7'(p), tx_q[k]});
      model_bank[p] = tx_q[k];
      if (inc) p = (p + 1) % 128;
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi_i = b;
    half();
    sclk_i = 1'b1;
    half();
    sclk_i = 1'b0;
  endtask

  // Drives tx_q MSB first, then 'extra' leading bits of xbyte, then raises select.
  task automatic xfer(input int extra, input logic [7:0] xbyte);
    model_xfer();
    @(negedge clk);
    csn_i = 1'b0;
    half();
    foreach (tx_q[i]) for (int b = 7; b >= 0; b--) send_bit(tx_q[i][b]);
    for (int b = 7; b > 7 - extra; b--) send_bit(xbyte[b]);
    half();
    csn_i = 1'b1;
    repeat (12) @(negedge clk);
    tx_q.delete();
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      rd_addr_i = 7'(i);
      #1;
      check(req, rd_data_o, model_bank[i]);
    end
    check({req, " pending writes"}, exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    foreach (model_bank[i]) model_bank[i] = 8'h00;
    // R9: select already low when reset ends.
    csn_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state.
    check("R10 strobe idle", wr_stb_o, 0);
    // R9: a valid-looking frame without a preceding fall must be ignored.
    begin
      logic [7:0] fr [3] = '{8'h94, 8'h05, 8'hA5};
      foreach (fr[i]) for (int b = 7; b >= 0; b--) send_bit(fr[i][b]);
    end
    half();
    csn_i = 1'b1;
    repeat (12) @(negedge clk);
    sweep("R9 R10 no start without fall");

    // R1 R4 R5: single write, MSB-first pattern.
    tx_q = '{8'h94, 8'h10, 8'h81};
    xfer(0, 8'h00);
    sweep("R1 R5 single write");

    // R6: auto-advance burst.
    tx_q = '{8'h94, 8'h80 | 8'h20, 8'h11, 8'h22, 8'h33};
    xfer(0, 8'h00);
    // R6: wrap 127 -> 0.
    tx_q = '{8'h94, 8'hFE, 8'h5A, 8'hC3, 8'h7E};
    xfer(0, 8'h00);
    sweep("R6 burst and wrap");

    // R7: fixed pointer, overwrite.
    tx_q = '{8'h94, 8'h40, 8'h01, 8'h02, 8'hEE};
    xfer(0, 8'h00);
    sweep("R7 fixed pointer");

    // R3: read request ignored.
    tx_q = '{8'h95, 8'h10, 8'hFF, 8'hFF};
    xfer(0, 8'h00);
    // R2: wrong identifier ignored.
    tx_q = '{8'h96, 8'h10, 8'hFF};
    xfer(0, 8'h00);
    tx_q = '{8'h14, 8'h10, 8'hFF};
    xfer(0, 8'h00);
    sweep("R2 R3 rejected headers");

    // R8: abort mid data byte, then mid pointer, then a normal transfer.
    tx_q = '{8'h94, 8'h30, 8'h99};
    xfer(5, 8'hF0);
    tx_q = '{8'h94};
    xfer(4, 8'h31);
    tx_q = '{8'h94, 8'h31, 8'h3C};
    xfer(0, 8'h00);
    sweep("R8 abort and restart");

    finish_run();
  end

endmodule